// File: doc/BRIEF.md
# Serial FIFO Interrupt Status Controller

This block watches the transmit and receive FIFOs of a synchronous serial port and turns what it sees into status bits and four interrupt request lines. It takes the occupancy of both FIFOs, two programmable thresholds, the push and pop strobes on each FIFO, a strobe marking the start of each serial transmit slot, the ready and valid flags of the control-data registers, and a frame sync input that is checked in slave mode. It does not contain the FIFOs, the shifter or any DMA logic.

Six of the eleven status bits are level conditions that follow their inputs live. Five are error flags that hold once set until software clears them. Software reads the status word and the interrupt-enable word through a small register port. Each interrupt line is the registered OR of its enabled sources: transmit request, receive request, control-data readiness, and a single error class that covers FIFO empty/full, overrun, underrun and early frame sync.

The early-sync detector counts serial bit ticks from the last accepted sync. In slave mode, a sync that arrives before the programmed frame length has been counted is flagged and is not accepted, so the count runs on.

Top module: `sfic_irq_ctrl`

## Requirements
- R1: Status bit 0 (transmit request) is 1 exactly while `tx_count` is less than or equal to `tx_thresh`.
- R2: Status bit 1 (receive request) is 1 exactly while `rx_count` is greater than or equal to `rx_thresh`.
- R3: Status bit 2 follows `tx_ctl_ready` and status bit 3 follows `rx_ctl_valid`, in the same cycle.
- R4: Status bit 4 is 1 while `tx_count` is 0. Status bit 5 is 1 while `rx_count` equals RX_DEPTH.
- R5: Status bit 6 (transmit underrun) is set at the clock edge after a cycle in which `tx_slot` is high and `tx_count` is 0.
- R6: At the clock edge after the triggering cycle, status bit 7 is set by `tx_push` when `tx_count` equals TX_DEPTH, bit 8 is set by `rx_push` when `rx_count` equals RX_DEPTH, and bit 9 is set by `rx_pop` when `rx_count` is 0.
- R7: A sync is seen when `sync_in` and `sclk_tick` are both high. Each `sclk_tick` that carries no accepted sync adds one to the bit count, which stops at its maximum. An accepted sync loads the count with 1. A seen sync counts as early when `slave_mode` is 1, a sync has already been accepted since reset, and the count is below `frame_len`. An early sync sets status bit 10 at the next edge and is not accepted. Every other seen sync is accepted.
- R8: Writing to address 0 clears each of status bits 6 to 10 whose write-data bit is 1. A set condition in the same cycle wins over the clear. Writes have no effect on status bits 0 to 5.
- R9: Address 1 holds the 11-bit enable word, one enable per status bit at the same position. It can be written and read back, and it resets to 0.
- R10: `irq_tx`, `irq_rx`, `irq_cc` and `irq_err` are registered. Each one equals, one cycle later, the OR of (status AND enable) over bit 0, bit 1, bits 2–3 and bits 4–10 respectively.
- R11: Reset clears the error flags, the enable word, all four interrupt lines and the frame-sync tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_count | input | TCW | Transmit FIFO occupancy |
| rx_count | input | RCW | Receive FIFO occupancy |
| tx_thresh | input | TCW | Transmit request threshold |
| rx_thresh | input | RCW | Receive request threshold |
| tx_push | input | 1 | Software write into the transmit FIFO |
| rx_push | input | 1 | Serial data arriving into the receive FIFO |
| rx_pop | input | 1 | Software read from the receive FIFO |
| tx_slot | input | 1 | Start of a serial transmit slot |
| tx_ctl_ready | input | 1 | Transmit control-data register can be written |
| rx_ctl_valid | input | 1 | Receive control-data register holds valid data |
| slave_mode | input | 1 | 1 selects slave framing |
| sclk_tick | input | 1 | One serial bit time has passed |
| sync_in | input | 1 | Frame sync, sampled with `sclk_tick` |
| frame_len | input | FW | Minimum number of bit ticks between syncs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data for `reg_addr` |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_cc | output | 1 | Control-data interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The functions most likely to meet in one cycle are a set condition on an error flag and a software write that clears the same flag. The bench provokes this on purpose, for example an underrun slot together with a clear of bit 6, and it also lets the two meet by chance under random stimulus. The judgement is made at the ports: the flag must read 1 in the next cycle, and `irq_err` must follow it one cycle after that. An early sync arriving in the same cycle as a write that clears bit 10 is covered the same way.

// File: rtl/sfic_pkg.sv
package sfic_pkg;
  localparam int NSRC    = 11;
  localparam int NSTICKY = 5;
  localparam int NLEVEL  = 6;

  // status bit positions
  localparam int B_TXREQ = 0;
  localparam int B_RXREQ = 1;
  localparam int B_TXCTL = 2;
  localparam int B_RXCTL = 3;
  localparam int B_TXEMP = 4;
  localparam int B_RXFUL = 5;
  localparam int B_TXUDR = 6;
  localparam int B_TXOVR = 7;
  localparam int B_RXOVR = 8;
  localparam int B_RXUDR = 9;
  localparam int B_FSERR = 10;

  function automatic logic at_or_below(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt <= lim;
  endfunction

  function automatic logic at_or_above(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/sfic_cond.sv
module sfic_cond #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic [TCW-1:0] tx_count,
  input  logic [RCW-1:0] rx_count,
  input  logic [TCW-1:0] tx_thresh,
  input  logic [RCW-1:0] rx_thresh,
  input  logic           tx_push,
  input  logic           rx_push,
  input  logic           rx_pop,
  input  logic           tx_slot,
  input  logic           tx_ctl_ready,
  input  logic           rx_ctl_valid,
  output logic [5:0]     lvl,
  output logic [3:0]     evt
);
  import sfic_pkg::*;

  logic tx_empty, tx_full, rx_empty, rx_full;

  assign tx_empty = (tx_count == '0);
  assign tx_full  = (32'(tx_count) == TX_DEPTH);
  assign rx_empty = (rx_count == '0);
  assign rx_full  = (32'(rx_count) == RX_DEPTH);

  always_comb begin
    lvl        = '0;
    lvl[B_TXREQ] = at_or_below(32'(tx_count), 32'(tx_thresh));
    lvl[B_RXREQ] = at_or_above(32'(rx_count), 32'(rx_thresh));
    lvl[B_TXCTL] = tx_ctl_ready;
    lvl[B_RXCTL] = rx_ctl_valid;
    lvl[B_TXEMP] = tx_empty;
    lvl[B_RXFUL] = rx_full;
  end

  // events map to sticky bits 6..9 in order
  assign evt[0] = tx_slot & tx_empty;
  assign evt[1] = tx_push & tx_full;
  assign evt[2] = rx_push & rx_full;
  assign evt[3] = rx_pop  & rx_empty;
endmodule

// File: rtl/sfic_frame_chk.sv
module sfic_frame_chk #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          sclk_tick,
  input  logic          sync_in,
  input  logic [FW-1:0] frame_len,
  output logic          early_evt,
  output logic          sync_ok
);
  logic [FW-1:0] bit_cnt;
  logic          armed;
  logic          sync_seen;

  assign sync_seen = sclk_tick & sync_in;
  assign early_evt = sync_seen & slave_mode & armed & (bit_cnt < frame_len);
  assign sync_ok   = sync_seen & ~early_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      armed   <= 1'b0;
    end else if (sync_ok) begin
      bit_cnt <= FW'(1);
      armed   <= 1'b1;
    end else if (sclk_tick && (bit_cnt != '1)) begin
      bit_cnt <= bit_cnt + FW'(1);
    end
  end
endmodule

// File: rtl/sfic_sticky.sv
module sfic_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sfic_irq_group.sv
module sfic_irq_group #(
  parameter int NS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] status,
  input  logic [NS-1:0] enable,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_cc,
  output logic          irq_err
);
  logic [NS-1:0] armed;
  assign armed = status & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_cc  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_tx  <= armed[0];
      irq_rx  <= armed[1];
      irq_cc  <= |armed[3:2];
      irq_err <= |armed[NS-1:4];
    end
  end
endmodule

// File: rtl/sfic_irq_ctrl.sv
module sfic_irq_ctrl #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int FW       = 4,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1),
  localparam int NS  = sfic_pkg::NSRC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TCW-1:0] tx_count,
  input  logic [RCW-1:0] rx_count,
  input  logic [TCW-1:0] tx_thresh,
  input  logic [RCW-1:0] rx_thresh,
  input  logic           tx_push,
  input  logic           rx_push,
  input  logic           rx_pop,
  input  logic           tx_slot,
  input  logic           tx_ctl_ready,
  input  logic           rx_ctl_valid,
  input  logic           slave_mode,
  input  logic           sclk_tick,
  input  logic           sync_in,
  input  logic [FW-1:0]  frame_len,
  input  logic           reg_we,
  input  logic           reg_addr,
  input  logic [NS-1:0]  reg_wdata,
  output logic [NS-1:0]  reg_rdata,
  output logic           irq_tx,
  output logic           irq_rx,
  output logic           irq_cc,
  output logic           irq_err
);
  import sfic_pkg::*;

  logic [NLEVEL-1:0]  lvl;
  logic [3:0]         fifo_evt;
  logic               fs_err_evt;
  logic               sync_ok;
  logic [NSTICKY-1:0] set_vec;
  logic [NSTICKY-1:0] clr_vec;
  logic [NSTICKY-1:0] sticky;
  logic [NS-1:0]      status;
  logic [NS-1:0]      enable;
  logic               wr_status, wr_enable;

  sfic_cond #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_cond (
    .tx_count, .rx_count, .tx_thresh, .rx_thresh,
    .tx_push, .rx_push, .rx_pop, .tx_slot,
    .tx_ctl_ready, .rx_ctl_valid,
    .lvl(lvl), .evt(fifo_evt)
  );

  sfic_frame_chk #(.FW(FW)) u_frame (
    .clk, .rst_n, .slave_mode, .sclk_tick, .sync_in, .frame_len,
    .early_evt(fs_err_evt), .sync_ok(sync_ok)
  );

  assign wr_status = reg_we & ~reg_addr;
  assign wr_enable = reg_we &  reg_addr;
  assign set_vec   = {fs_err_evt, fifo_evt};
  assign clr_vec   = wr_status ? reg_wdata[NS-1:NLEVEL] : '0;

  sfic_sticky #(.N(NSTICKY)) u_sticky (
    .clk, .rst_n, .set_vec(set_vec), .clr_vec(clr_vec), .flags(sticky)
  );

  assign status = {sticky, lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable <= '0;
    else if (wr_enable) enable <= reg_wdata;
  end

  assign reg_rdata = reg_addr ? enable : status;

  sfic_irq_group #(.NS(NS)) u_irq (
    .clk, .rst_n, .status(status), .enable(enable),
    .irq_tx, .irq_rx, .irq_cc, .irq_err
  );
endmodule

// File: rtl/sfic_irq_ctrl_chk.sv
module sfic_irq_ctrl_chk #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TCW-1:0] tx_count,
  input logic [RCW-1:0] rx_count,
  input logic           tx_push,
  input logic           rx_push,
  input logic           rx_pop,
  input logic           tx_slot,
  input logic           slave_mode,
  input logic           fs_err_evt,
  input logic [10:0]    status,
  input logic [10:0]    enable,
  input logic [4:0]     clr_vec,
  input logic           irq_tx,
  input logic           irq_cc,
  input logic           irq_err
);
  a_r5_udr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_slot && tx_count == '0) |=> status[6]);

  a_r6_txovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && 32'(tx_count) == TX_DEPTH) |=> status[7]);

  a_r6_rxovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && 32'(rx_count) == RX_DEPTH) |=> status[8]);

  a_r6_rxudr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_count == '0) |=> status[9]);

  a_r7_fs_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    fs_err_evt |-> slave_mode);

  a_r7_fs_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fs_err_evt |=> status[10]);

  // R8: error flags not being cleared stay set
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((status[10:6] & ~clr_vec) != '0) |=>
      ((status[10:6] & $past(status[10:6] & ~clr_vec)) == $past(status[10:6] & ~clr_vec)));

  a_r10_irq_tx: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == $past(status[0] & enable[0]));

  a_r10_irq_cc: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cc == $past(|(status[3:2] & enable[3:2])));

  a_r10_irq_err: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == $past(|(status[10:4] & enable[10:4])));
endmodule

bind sfic_irq_ctrl sfic_irq_ctrl_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
  .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .tx_slot(tx_slot),
  .slave_mode(slave_mode), .fs_err_evt(fs_err_evt), .status(status),
  .enable(enable), .clr_vec(clr_vec), .irq_tx(irq_tx), .irq_cc(irq_cc),
  .irq_err(irq_err)
);

// File: tb/sfic_irq_ctrl_test.sv
module sfic_irq_ctrl_test;
  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam int FW  = 4;
  localparam int TCW = $clog2(TXD + 1);
  localparam int RCW = $clog2(RXD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TCW-1:0] tx_count = '0, tx_thresh = '0;
  logic [RCW-1:0] rx_count = '0, rx_thresh = '0;
  logic tx_push = 0, rx_push = 0, rx_pop = 0, tx_slot = 0;
  logic tx_ctl_ready = 0, rx_ctl_valid = 0, slave_mode = 0;
  logic sclk_tick = 0, sync_in = 0;
  logic [FW-1:0] frame_len = '0;
  logic reg_we = 0, reg_addr = 0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic irq_tx, irq_rx, irq_cc, irq_err;

  always #10 clk = ~clk;

  sfic_irq_ctrl #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .FW(FW)) uut (
    .clk, .rst_n, .tx_count, .rx_count, .tx_thresh, .rx_thresh,
    .tx_push, .rx_push, .rx_pop, .tx_slot, .tx_ctl_ready, .rx_ctl_valid,
    .slave_mode, .sclk_tick, .sync_in, .frame_len,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .irq_tx, .irq_rx, .irq_cc, .irq_err
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // bench model state
  logic [4:0]    m_sticky;
  logic [10:0]   m_en;
  logic [FW-1:0] m_cnt;
  logic          m_armed;

  function automatic logic [5:0] exp_level();
    logic [5:0] v = '0;
    if (!(tx_count > tx_thresh)) v[0] = 1'b1;
    if (!(rx_count < rx_thresh)) v[1] = 1'b1;
    v[2] = tx_ctl_ready;
    v[3] = rx_ctl_valid;
    if (tx_count == 0) v[4] = 1'b1;
    if (rx_count == RXD) v[5] = 1'b1;
    return v;
  endfunction

  function automatic string tag_of_bit(input int b);
    if (b == 0) return "R1";
    if (b == 1) return "R2";
    if (b <= 3) return "R3";
    if (b <= 5) return "R4";
    if (b == 6) return "R5";
    if (b <= 9) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    tx_push = 0; rx_push = 0; rx_pop = 0; tx_slot = 0;
    sclk_tick = 0; sync_in = 0; reg_we = 0; reg_wdata = '0;
  endtask

  // called just after a falling edge, with inputs already set
  task automatic cycle();
    logic [10:0] st, diff;
    logic [3:0]  irq_exp;
    logic [4:0]  setv, clrv;
    logic        seen, early;
    int          lo;
    st = {m_sticky, exp_level()};
    #2;
    if (reg_addr) check("R9", 32'(reg_rdata), 32'(m_en));
    else begin
      diff = reg_rdata ^ st;
      lo = 0;
      for (int b = 10; b >= 0; b--) if (diff[b]) lo = b;
      check(tag_of_bit(lo), 32'(reg_rdata), 32'(st));
    end
    irq_exp[0] = st[0] & m_en[0];
    irq_exp[1] = st[1] & m_en[1];
    irq_exp[2] = (st[2] & m_en[2]) | (st[3] & m_en[3]);
    irq_exp[3] = (st[10:4] & m_en[10:4]) != 0;
    seen  = sclk_tick & sync_in;
    early = seen & slave_mode & m_armed & (m_cnt < frame_len);
    setv[0] = tx_slot && tx_count == 0;
    setv[1] = tx_push && tx_count == TXD;
    setv[2] = rx_push && rx_count == RXD;
    setv[3] = rx_pop  && rx_count == 0;
    setv[4] = early;
    clrv = (reg_we && !reg_addr) ? reg_wdata[10:6] : 5'b0;
    m_sticky = setv | (m_sticky & ~clrv);
    if (reg_we && reg_addr) m_en = reg_wdata;
    if (seen && !early) begin m_cnt = 1; m_armed = 1; end
    else if (sclk_tick && m_cnt != {FW{1'b1}}) m_cnt = m_cnt + 1'b1;
    @(posedge clk);
    #2;
    check("R10", {28'd0, irq_err, irq_cc, irq_rx, irq_tx}, {28'd0, irq_exp});
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_sticky = '0; m_en = '0; m_cnt = '0; m_armed = 0;
    tx_thresh = 5'd4; rx_thresh = 5'd8;
    repeat (3) @(negedge clk);
    // R11: reset state seen at the ports
    check("R11", {28'd0, irq_err, irq_cc, irq_rx, irq_tx}, 32'd0);
    reg_addr = 1; #1;
    check("R11", 32'(reg_rdata), 32'd0);
    reg_addr = 0; #1;
    check("R11", 32'(reg_rdata[10:6]), 32'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // enable everything (R9)
    reg_we = 1; reg_addr = 1; reg_wdata = 11'h7FF; cycle(); quiet(); reg_addr = 0;
    // R1 threshold boundary
    tx_count = 5'd4; cycle();
    tx_count = 5'd5; cycle();
    // R2 threshold boundary
    rx_count = 5'd7; cycle();
    rx_count = 5'd8; cycle();
    // R4 full and empty
    rx_count = 5'd16; tx_count = 5'd0; cycle();
    // R3 control flags
    tx_ctl_ready = 1; cycle(); rx_ctl_valid = 1; tx_ctl_ready = 0; cycle(); rx_ctl_valid = 0;
    // R5 underrun then R8 collision: set wins over clear
    tx_slot = 1; cycle();
    reg_we = 1; reg_wdata = 11'h040; cycle();
    tx_slot = 0; cycle();
    reg_we = 0; cycle();
    // R8: write to level bits has no effect
    reg_we = 1; reg_wdata = 11'h03F; cycle(); quiet();
    // R6 overruns and underrun
    tx_count = 5'd16; tx_push = 1; cycle(); quiet();
    rx_count = 5'd16; rx_push = 1; cycle(); quiet();
    rx_count = 5'd0;  rx_pop = 1;  cycle(); quiet();
    reg_we = 1; reg_wdata = 11'h7C0; cycle(); quiet(); cycle();
    // R7: early sync in slave mode, then an on-time one
    slave_mode = 1; frame_len = 4'd4;
    sclk_tick = 1; sync_in = 1; cycle();
    sync_in = 0; cycle(); cycle();
    sync_in = 1; cycle();
    sync_in = 0; cycle();
    sync_in = 1; cycle();
    sclk_tick = 0; sync_in = 0; cycle();
    reg_we = 1; reg_wdata = 11'h400; cycle(); quiet(); cycle();
    // R7: master mode never flags
    slave_mode = 0; sclk_tick = 1; sync_in = 1; cycle(); cycle(); quiet(); cycle();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      tx_count     = 5'($urandom_range(TXD, 0));
      rx_count     = 5'($urandom_range(RXD, 0));
      if ($urandom_range(7, 0) == 0) tx_thresh = 5'($urandom_range(TXD, 0));
      if ($urandom_range(7, 0) == 0) rx_thresh = 5'($urandom_range(RXD, 0));
      tx_push      = ($urandom_range(3, 0) == 0);
      rx_push      = ($urandom_range(3, 0) == 0);
      rx_pop       = ($urandom_range(3, 0) == 0);
      tx_slot      = ($urandom_range(3, 0) == 0);
      tx_ctl_ready = $urandom_range(1, 0);
      rx_ctl_valid = $urandom_range(1, 0);
      if ($urandom_range(63, 0) == 0) slave_mode = ~slave_mode;
      if ($urandom_range(31, 0) == 0) frame_len = 4'($urandom_range(6, 1));
      sclk_tick    = $urandom_range(1, 0);
      sync_in      = ($urandom_range(3, 0) == 0);
      reg_we       = ($urandom_range(5, 0) == 0);
      reg_addr     = $urandom_range(1, 0);
      reg_wdata    = 11'($urandom);
      cycle();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule